// File: doc/BRIEF.md
# Two-Step Subranging Conversion Sequencer

This block controls an 8-bit analog-to-digital conversion that is split into two 4-bit flash steps. On a start request it first samples the thermometer word of a coarse comparator bank and reduces it to the upper half of the result. That coarse code is driven to an external 4-bit DAC, and the DAC's analog level is subtracted from the input to form a residue.

After a programmable number of settling cycles, the sequencer samples a second comparator bank that looks at the residue. It encodes that word as the lower half of the result. The two halves are joined, a one-cycle valid pulse is raised, and a full-scale flag is produced so that several converters can be cascaded.

The comparator banks, the DAC and the residue path sit outside the block. The conversion is split into stages of `STAGE_W` bits, giving `2^STAGE_W - 1` comparators per bank. The settling wait `SETTLE_CYC` is given in clock cycles.

Top module: `subr_two_step_seq`

## Requirements
- R1: After reset, `busy_o`, `valid_o`, `ovf_o`, `result_o` and `dac_code_o` are all zero.
- R2: On the first edge after a start is accepted, the coarse bank is sampled. Its code drives `dac_code_o` from the next cycle until the next coarse sample, and it does not change during the settling wait. The code is one plus the index of the highest set comparator bit, with bit 0 the lowest threshold.
- R3: The DAC code is held for exactly `SETTLE_CYC` cycles before the fine bank is sampled. `valid_o` is first high `SETTLE_CYC + 2` rising edges after the edge that accepted `start_i`.
- R4: `result_o` equals the coarse code in bits [7:4] and the fine code in bits [3:0].
- R5: Both encoders tolerate bubbles. A zero below a set bit is ignored, the highest set bit decides the code, and an all-zero word gives code 0.
- R6: `ovf_o` is high with a result exactly when both the coarse and fine codes are at their maximum, so the result reads 8'hFF. Otherwise it is low.
- R7: `valid_o` is high for one cycle per conversion. `result_o` and `ovf_o` change only together with that pulse and then hold.
- R8: `busy_o` is high from the cycle after the accepting edge through the cycle in which `valid_o` is high. It is low at all other times.
- R9: A start request while `busy_o` is high is dropped. It neither restarts nor queues a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Conversion request, accepted when idle |
| coarse_therm_i | input | 15 | Coarse comparator bank, bit i set when input exceeds threshold i+1 |
| fine_therm_i | input | 15 | Residue comparator bank, same ordering |
| dac_code_o | output | 4 | Coarse code driven to the external DAC |
| busy_o | output | 1 | Conversion in progress |
| valid_o | output | 1 | One-cycle result strobe |
| result_o | output | 8 | Joined conversion result |
| ovf_o | output | 1 | Full-scale flag for cascading |

## Verification
The bench models a DAC whose residue comparators read all ones until the DAC code has been stable for `SETTLE_CYC` cycles. A sequencer that samples the fine bank one cycle too early therefore returns a low nibble of 15 instead of the true residue. Inputs at the nibble boundaries (15/16, 239/240, 254/255) and above full scale expose a swapped nibble order, an off-by-one encoder, or an overflow flag raised on the coarse maximum alone. Raw comparator words with bubbles separate a highest-bit encoder from a bit-count or lowest-zero encoder. A start pulse injected mid-conversion catches a design that restarts the sequence or stores the request for later.

// File: rtl/subr_pkg.sv
package subr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_COARSE,
      ST_SETTLE,
      ST_FINE,
      ST_DONE
   } conv_state_e;

endpackage

// File: rtl/subr_therm_enc.sv
module subr_therm_enc #(
   parameter int STAGE_W = 4,
   localparam int THERM_W = (1 << STAGE_W) - 1
) (
   input  logic [THERM_W-1:0] therm_i,
   output logic [STAGE_W-1:0] code_o
);

   // highest set bit wins; bubbles below it are ignored
   always_comb begin
      code_o = '0;
      for (int i = 0; i < THERM_W; i++) begin
         if (therm_i[i]) code_o = STAGE_W'(i + 1);
      end
   end

   // R5: nothing set above the encoded position, and the position itself is set
   always_comb begin
      a_r5_enc_top : assert ((therm_i >> code_o) == '0);
      if (code_o != '0) begin
         a_r5_enc_hit : assert (therm_i[code_o - 1'b1]);
      end
   end

endmodule

// File: rtl/subr_settle_timer.sv
module subr_settle_timer #(
   parameter int SETTLE_CYC = 4,
   localparam int CNT_W = $clog2(SETTLE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic done_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CNT_W'(SETTLE_CYC - 1);
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign done_o = (cnt_q == '0);

   generate
      if (SETTLE_CYC > 1) begin : g_multi
         // R3: a freshly loaded wait never reports done on the next cycle
         a_r3_settle_wait : assert property (@(posedge clk) disable iff (!rst_n)
            load_i |=> !done_o);
      end
   endgenerate

endmodule

// File: rtl/subr_two_step_seq.sv
module subr_two_step_seq
   import subr_pkg::*;
#(
   parameter int STAGE_W    = 4,
   parameter int SETTLE_CYC = 4,
   localparam int THERM_W = (1 << STAGE_W) - 1,
   localparam int RES_W   = 2 * STAGE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [THERM_W-1:0] coarse_therm_i,
   input  logic [THERM_W-1:0] fine_therm_i,
   output logic [STAGE_W-1:0] dac_code_o,
   output logic               busy_o,
   output logic               valid_o,
   output logic [RES_W-1:0]   result_o,
   output logic               ovf_o
);

   generate
      if (STAGE_W < 2 || STAGE_W > 6) begin : g_bad_stage
         $error("subr_two_step_seq: STAGE_W must lie in 2..6");
      end
      if (SETTLE_CYC < 1) begin : g_bad_settle
         $error("subr_two_step_seq: SETTLE_CYC must be at least 1");
      end
   endgenerate

   conv_state_e        state_q;
   logic [STAGE_W-1:0] coarse_code;
   logic [STAGE_W-1:0] fine_code;
   logic [STAGE_W-1:0] coarse_q;
   logic [RES_W-1:0]   result_q;
   logic               ovf_q;
   logic               valid_q;
   logic               settle_done;

   subr_therm_enc #(.STAGE_W(STAGE_W)) u_enc_coarse (
      .therm_i (coarse_therm_i),
      .code_o  (coarse_code)
   );

   subr_therm_enc #(.STAGE_W(STAGE_W)) u_enc_fine (
      .therm_i (fine_therm_i),
      .code_o  (fine_code)
   );

   subr_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (state_q == ST_COARSE),
      .done_o (settle_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         coarse_q <= '0;
         result_q <= '0;
         ovf_q    <= 1'b0;
         valid_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) state_q <= ST_COARSE;
            end
            ST_COARSE: begin
               coarse_q <= coarse_code;
               state_q  <= ST_SETTLE;
            end
            ST_SETTLE: begin
               if (settle_done) state_q <= ST_FINE;
            end
            ST_FINE: begin
               result_q <= {coarse_q, fine_code};
               ovf_q    <= (&coarse_q) & (&fine_code);
               valid_q  <= 1'b1;
               state_q  <= ST_DONE;
            end
            ST_DONE: begin
               valid_q <= 1'b0;
               state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign dac_code_o = coarse_q;
   assign busy_o     = (state_q != ST_IDLE);
   assign valid_o    = valid_q;
   assign result_o   = result_q;
   assign ovf_o      = ovf_q;

   // R2: DAC code cannot move while the residue is settling
   a_r2_dac_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SETTLE) |=> $stable(dac_code_o));

   // R6: overflow only with a full-scale result
   a_r6_ovf_full : assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (&result_o));

   // R7: strobe lasts a single cycle
   a_r7_valid_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R7: result only moves with the strobe
   a_r7_result_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |=> (valid_o || $stable(result_o)));

   // R8: the strobe lies inside the busy window
   a_r8_busy_valid : assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> busy_o);

   // R9: a busy sequencer never re-enters the coarse step directly
   a_r9_no_restart : assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (state_q != ST_COARSE));

endmodule

// File: tb/tb_subr_two_step_seq.sv
`timescale 1ns/1ps
module tb_subr_two_step_seq;

   localparam int STG  = 4;
   localparam int SET  = 4;
   localparam int TW   = (1 << STG) - 1;
   localparam int STEP = 1 << STG;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [TW-1:0] coarse_therm, fine_therm;
   logic [STG-1:0] dac_code_o;
   logic          busy_o, valid_o, ovf_o;
   logic [2*STG-1:0] result_o;

   int n_chk = 0;
   int n_fail = 0;

   int vin = 0;
   bit use_raw = 1'b0;
   logic [TW-1:0] raw_coarse = '0, raw_fine = '0;
   int set_cnt = 0;
   logic [STG-1:0] dac_last = '0;

   always #5 clk = ~clk;

   subr_two_step_seq #(.STAGE_W(STG), .SETTLE_CYC(SET)) dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .start_i        (start_i),
      .coarse_therm_i (coarse_therm),
      .fine_therm_i   (fine_therm),
      .dac_code_o     (dac_code_o),
      .busy_o         (busy_o),
      .valid_o        (valid_o),
      .result_o       (result_o),
      .ovf_o          (ovf_o)
   );

   // external DAC settling model: residue bank unreliable (all ones) until settled
   always @(negedge clk) begin
      if (dac_code_o != dac_last) set_cnt = 0;
      else if (set_cnt < 1000) set_cnt = set_cnt + 1;
      dac_last = dac_code_o;
   end

   always_comb begin
      for (int i = 0; i < TW; i++) begin
         coarse_therm[i] = use_raw ? raw_coarse[i] : (vin >= STEP * (i + 1));
         if (use_raw)
            fine_therm[i] = raw_fine[i];
         else if (set_cnt < SET)
            fine_therm[i] = 1'b1;
         else
            fine_therm[i] = ((vin - STEP * int'(dac_code_o)) >= (i + 1));
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // one conversion; poke injects a start request while busy
   task automatic do_conv(input logic [7:0] exp_res, input logic exp_ovf,
                          input logic [3:0] exp_dac, input bit poke);
      int lat;
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      check(busy_o == 1'b1, "R8", "busy after accept", busy_o, 1);
      lat = 0;
      while (!valid_o && lat < 100) begin
         start_i = (poke && lat == 2);
         @(negedge clk);
         lat++;
      end
      start_i = 1'b0;
      check(lat == SET + 2, "R3", "latency", lat, SET + 2);
      check(result_o == exp_res, "R4", "result", result_o, exp_res);
      check(ovf_o == exp_ovf, "R6", "overflow", ovf_o, exp_ovf);
      check(dac_code_o == exp_dac, "R2", "dac code", dac_code_o, exp_dac);
      check(busy_o == 1'b1, "R8", "busy with valid", busy_o, 1);
      @(negedge clk);
      check(valid_o == 1'b0, "R7", "valid one cycle", valid_o, 0);
      check(busy_o == 1'b0, "R8", "busy cleared", busy_o, 0);
      check(result_o == exp_res, "R7", "result held", result_o, exp_res);
      if (poke) begin
         for (int k = 0; k < SET + 4; k++) begin
            @(negedge clk);
            check(!valid_o && !busy_o, "R9", "no queued conversion",
                  {valid_o, busy_o}, 0);
         end
      end
   endtask

   task automatic t_reset();
      check(busy_o == 0 && valid_o == 0 && ovf_o == 0, "R1", "flags at reset",
            {busy_o, valid_o, ovf_o}, 0);
      check(result_o == 0 && dac_code_o == 0, "R1", "data at reset",
            {result_o, dac_code_o}, 0);
   endtask

   task automatic t_analog(input int v);
      int e;
      use_raw = 1'b0;
      vin = v;
      e = (v > 255) ? 255 : v;
      do_conv(8'(e), (e == 255), 4'(e / STEP), 1'b0);
   endtask

   task automatic t_bubble();
      // R5: coarse bubbles -> highest bit 6 -> 7; fine highest bit 9 -> 10
      use_raw = 1'b1;
      raw_coarse = 15'b000_0000_0101_1011;
      raw_fine   = 15'b000_0010_1101_1111;
      do_conv(8'h7A, 1'b0, 4'h7, 1'b0);
      // R5: all-zero coarse, single fine bit 0 -> 0x01
      raw_coarse = '0;
      raw_fine   = 15'b000_0000_0000_0001;
      do_conv(8'h01, 1'b0, 4'h0, 1'b0);
      // R6: full coarse, fine top set with a bubble at bit 0
      raw_coarse = '1;
      raw_fine   = 15'b111_1111_1111_1110;
      do_conv(8'hFF, 1'b1, 4'hF, 1'b0);
      use_raw = 1'b0;
   endtask

   task automatic t_busy_start();
      use_raw = 1'b0;
      vin = 93;
      do_conv(8'd93, 1'b0, 4'd5, 1'b1);
   endtask

   initial begin
      #200_000;
      n_fail++;
      $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_analog(0);
      t_analog(15);
      t_analog(16);
      t_analog(127);
      t_analog(128);
      t_analog(200);
      t_analog(239);
      t_analog(240);
      t_analog(254);
      t_analog(255);   // R6 full scale
      t_analog(300);   // R6 beyond full scale
      t_analog(77);    // R6 flag clears again
      t_bubble();
      t_busy_start();
      finish_run();
   end

endmodule